// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block generates the digital drive-level codes for a low-multiplex liquid-crystal panel with up to four backplanes and a parameterised number of segment lines, 32 by default. A host fills an internal pixel store through a byte-wide write port. The store's address pointer can be loaded to any location, and it then moves forward by one after every data byte. A frame sequencer steps through one phase per active backplane on each frame-rate tick. On every phase, each segment line gets an "on" or "off" code. That code comes from the stored bit for the backplane that is currently selected.

Four multiplex ratios are selectable: static, duplex, triplex and quad. The pixel store is 4 bits wide per segment. In static mode those 4 bits act as four separate one-bit images. In duplex mode they act as two separate two-bit images. A bank-select input picks which image is shown, so the host can prepare one picture while another is on the panel. The polarity of every drive code reverses after each complete frame, so the panel sees no net DC. Converting the codes to analog bias voltages, and the host's serial link, are handled outside this block.

Top module: `lcd_mux_driver`

## Requirements
- R1: `mode` selects the multiplex ratio: 0 static, 1 duplex, 2 triplex, 3 quad. A frame has `mode`+1 phases, numbered 0 to `mode`. Each `frame_tick` pulse moves the phase forward by one, and the phase returns to 0 after phase `mode`. Backplanes with an index above `mode` always output MID.
- R2: The drive polarity starts at 0 after reset. It inverts on every tick that takes the phase from `mode` back to 0.
- R3: Each backplane is driven by a 2-bit field `bp_lvl[2i+1:2i]`, with codes LO=2'b00, MID=2'b01 and HI=2'b11. Code 2'b10 never appears. The backplane whose index equals the phase outputs HI when polarity is 0 and LO when polarity is 1. Every other backplane outputs MID.
- R4: Segment s uses the field `seg_lvl[2s+1:2s]`. When its selected stored bit is 1, it outputs LO when polarity is 0 and HI when polarity is 1.
- R5: When a segment's selected bit is 0, it outputs MID in duplex, triplex and quad modes. In static mode it outputs the same code as backplane 0.
- R6: In triplex and quad modes the selected bit of each segment is bit [phase] of its stored word, and `bank_sel` has no effect.
- R7: In static mode the selected bit is bit [`bank_sel`] of the stored word.
- R8: In duplex mode the selected bit is bit {`bank_sel[0]`, phase[0]}. `bank_sel[1]` has no effect.
- R9: A cycle with `wr_en` high stores `wr_data[3:0]` into the word at the pointer and moves the pointer forward by one. `wr_data[7:4]` is ignored. Word s belongs to segment s.
- R10: A cycle with `ptr_load` high sets the pointer to `ptr_val`. If `wr_en` is high in the same cycle, the byte is stored at `ptr_val` and the pointer becomes `ptr_val`+1.
- R11: A write at address NSEG-1 leaves the pointer at 0.
- R12: While `rst` is high, all outputs are MID. Reset sets the phase to 0, the polarity to 0 and the pointer to 0. Stored pixel data is kept through reset.
- R13: The outputs are registered. A change of phase, polarity, stored data, `mode` or `bank_sel` shows at the outputs one clock after it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Multiplex ratio select |
| bank_sel | input | 2 | Image select for static and duplex modes |
| frame_tick | input | 1 | One-cycle phase-advance enable |
| ptr_load | input | 1 | Load the write pointer from `ptr_val` |
| ptr_val | input | ADDR_W (5) | Start address for subsequent writes |
| wr_en | input | 1 | Write `wr_data` at the pointer |
| wr_data | input | 8 | Host data byte, low 4 bits stored |
| bp_lvl | output | 8 | Backplane drive codes, 2 bits per backplane |
| seg_lvl | output | 2*NSEG (64) | Segment drive codes, 2 bits per segment |

## Verification
The bench targets the pointer's wrap from the last address to 0 and the write that arrives in the same cycle as a pointer load. A design that got the wrap wrong would write past the store or leave a gap. A design that got the same-cycle case wrong would put the byte at the old pointer. The bench also checks the frame boundary in each mode. A wrong phase limit shows up as an extra active backplane or a polarity flip at the wrong time. Bank selection is checked in all four modes. A design that mixed up the bit index would show the wrong image in static or duplex mode, or would let `bank_sel` change a triplex or quad display. The bench also checks the static-mode "off" code, which must track the backplane and not rest at MID.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int NBP = 4;

  typedef enum logic [1:0] {
    MODE_STATIC  = 2'b00,
    MODE_DUPLEX  = 2'b01,
    MODE_TRIPLEX = 2'b10,
    MODE_QUAD    = 2'b11
  } lcd_mode_e;

  localparam logic [1:0] LV_LO  = 2'b00;
  localparam logic [1:0] LV_MID = 2'b01;
  localparam logic [1:0] LV_HI  = 2'b11;
endpackage

// File: rtl/lcd_wr_port.sv
module lcd_wr_port #(
  parameter int NSEG   = 32,
  parameter int ADDR_W = $clog2(NSEG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ptr_load,
  input  logic [ADDR_W-1:0]        ptr_val,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [lcd_pkg::NBP-1:0]  mem_wd
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NSEG - 1);

  logic [ADDR_W-1:0] ptr_q;

  // a load in the same cycle redirects the write to the new start
  assign mem_addr = ptr_load ? ptr_val : ptr_q;
  assign mem_we   = wr_en;
  assign mem_wd   = wr_data[lcd_pkg::NBP-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (wr_en) begin
      ptr_q <= (mem_addr == LAST) ? '0 : mem_addr + 1'b1;
    end else if (ptr_load) begin
      ptr_q <= ptr_val;
    end
  end
endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int NSEG   = 32,
  parameter int ADDR_W = $clog2(NSEG)
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [lcd_pkg::NBP-1:0]       wd,
  output logic [NSEG*lcd_pkg::NBP-1:0]  words
);
  logic [lcd_pkg::NBP-1:0] mem [NSEG];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_flat
    assign words[s*lcd_pkg::NBP +: lcd_pkg::NBP] = mem[s];
  end
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       frame_tick,
  output logic [1:0] phase,
  output logic       pol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      pol   <= 1'b0;
    end else if (frame_tick) begin
      if (phase >= mode) begin
        phase <= '0;
        pol   <= ~pol;
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end
endmodule

// File: rtl/lcd_level_gen.sv
module lcd_level_gen #(
  parameter int NSEG = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    mode,
  input  logic [1:0]                    bank_sel,
  input  logic [1:0]                    phase,
  input  logic                          pol,
  input  logic [NSEG*lcd_pkg::NBP-1:0]  words,
  output logic [2*lcd_pkg::NBP-1:0]     bp_lvl,
  output logic [2*NSEG-1:0]             seg_lvl
);
  import lcd_pkg::*;

  logic [1:0]        bsel;
  logic [1:0]        sel_code;
  logic [1:0]        on_code;
  logic [1:0]        off_code;
  logic [2*NBP-1:0]  bp_n;
  logic [2*NSEG-1:0] seg_n;

  always_comb begin
    case (lcd_mode_e'(mode))
      MODE_STATIC: bsel = bank_sel;
      MODE_DUPLEX: bsel = {bank_sel[0], phase[0]};
      default:     bsel = phase;
    endcase
    sel_code = pol ? LV_LO : LV_HI;
    on_code  = pol ? LV_HI : LV_LO;
    off_code = (lcd_mode_e'(mode) == MODE_STATIC) ? sel_code : LV_MID;
  end

  for (genvar i = 0; i < NBP; i++) begin : g_bp
    assign bp_n[2*i +: 2] = (2'(i) > mode)  ? LV_MID :
                            (2'(i) == phase) ? sel_code : LV_MID;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [NBP-1:0] word;
    assign word = words[s*NBP +: NBP];
    assign seg_n[2*s +: 2] = word[bsel] ? on_code : off_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_lvl  <= {NBP{LV_MID}};
      seg_lvl <= {NSEG{LV_MID}};
    end else begin
      bp_lvl  <= bp_n;
      seg_lvl <= seg_n;
    end
  end
endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver #(
  parameter int NSEG   = 32,
  parameter int ADDR_W = $clog2(NSEG)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  mode,
  input  logic [1:0]                  bank_sel,
  input  logic                        frame_tick,
  input  logic                        ptr_load,
  input  logic [ADDR_W-1:0]           ptr_val,
  input  logic                        wr_en,
  input  logic [7:0]                  wr_data,
  output logic [2*lcd_pkg::NBP-1:0]   bp_lvl,
  output logic [2*NSEG-1:0]           seg_lvl
);
  logic                          mem_we;
  logic [ADDR_W-1:0]             mem_addr;
  logic [lcd_pkg::NBP-1:0]       mem_wd;
  logic [NSEG*lcd_pkg::NBP-1:0]  words;
  logic [1:0]                    phase;
  logic                          pol;

  lcd_wr_port #(.NSEG(NSEG), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .wr_en(wr_en), .wr_data(wr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wd(mem_wd)
  );

  lcd_disp_ram #(.NSEG(NSEG), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wd(mem_wd), .words(words)
  );

  lcd_phase_seq u_seq (
    .clk(clk), .rst(rst), .mode(mode), .frame_tick(frame_tick),
    .phase(phase), .pol(pol)
  );

  lcd_level_gen #(.NSEG(NSEG)) u_lvl (
    .clk(clk), .rst(rst), .mode(mode), .bank_sel(bank_sel),
    .phase(phase), .pol(pol), .words(words),
    .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
  );
endmodule

// File: rtl/lcd_mux_driver_chk.sv
module lcd_mux_driver_chk #(
  parameter int NSEG = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic [1:0]                mode,
  input logic [2*lcd_pkg::NBP-1:0] bp_lvl,
  input logic [2*NSEG-1:0]         seg_lvl
);
  import lcd_pkg::*;

  logic [NBP-1:0] bp_act;
  logic           bad_code;
  logic           rst_d;

  always_comb begin
    bad_code = 1'b0;
    for (int i = 0; i < NBP; i++) begin
      bp_act[i] = (bp_lvl[2*i +: 2] != LV_MID);
      if (bp_lvl[2*i +: 2] == 2'b10) bad_code = 1'b1;
    end
    for (int s = 0; s < NSEG; s++) begin
      if (seg_lvl[2*s +: 2] == 2'b10) bad_code = 1'b1;
    end
  end

  always_ff @(posedge clk) rst_d <= rst;

  assert_one_backplane_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bp_act));

  assert_legal_codes_R3: assert property (@(posedge clk) disable iff (rst)
    !bad_code);

  assert_static_unused_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == MODE_STATIC) |-> (bp_lvl[2*NBP-1:2] == {(NBP-1){LV_MID}}));

  assert_duplex_unused_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == MODE_DUPLEX) |-> (bp_lvl[2*NBP-1:4] == {(NBP-2){LV_MID}}));

  assert_reset_mid_R12: assert property (@(posedge clk)
    (rst_d && !rst) |-> (bp_lvl == {NBP{LV_MID}} && seg_lvl == {NSEG{LV_MID}}));
endmodule

bind lcd_mux_driver lcd_mux_driver_chk #(.NSEG(NSEG)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
);

// File: tb/sim_lcd_mux_driver.sv
module sim_lcd_mux_driver;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 32;
  localparam int AW = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        mode = 2'd3;
  logic [1:0]        bank_sel = 2'd0;
  logic              frame_tick = 1'b0;
  logic              ptr_load = 1'b0;
  logic [AW-1:0]     ptr_val = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        bp_lvl;
  logic [2*NSEG-1:0] seg_lvl;

  int n_checks = 0;
  int n_fail = 0;

  logic [3:0] shadow [NSEG];
  int         mptr = 0;
  int         m_phase = 0;
  bit         m_pol = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mux_driver #(.NSEG(NSEG)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .bank_sel(bank_sel),
    .frame_tick(frame_tick), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .wr_en(wr_en), .wr_data(wr_data), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
  );

  function automatic logic [7:0] exp_bp();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      if (i > int'(mode) || i != m_phase) v[2*i +: 2] = 2'b01;
      else v[2*i +: 2] = m_pol ? 2'b00 : 2'b11;
    end
    return v;
  endfunction

  function automatic logic [2*NSEG-1:0] exp_seg();
    logic [2*NSEG-1:0] v;
    int b;
    if (mode == 2'd0) b = int'(bank_sel);
    else if (mode == 2'd1) b = 2 * int'(bank_sel[0]) + (m_phase % 2);
    else b = m_phase;
    for (int s = 0; s < NSEG; s++) begin
      if (shadow[s][b]) v[2*s +: 2] = m_pol ? 2'b11 : 2'b00;
      else if (mode == 2'd0) v[2*s +: 2] = m_pol ? 2'b00 : 2'b11;
      else v[2*s +: 2] = 2'b01;
    end
    return v;
  endfunction

  task automatic check_vec(string req, logic [2*NSEG-1:0] act, logic [2*NSEG-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_out(string req);
    check_vec({req, " bp"}, {56'd0, bp_lvl}, {56'd0, exp_bp()});
    check_vec({req, " seg"}, seg_lvl, exp_seg());
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mptr = 0; m_phase = 0; m_pol = 1'b0;
    settle();
  endtask

  task automatic wr_byte(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[mptr] = d[3:0];
    mptr = (mptr == NSEG-1) ? 0 : mptr + 1;
  endtask

  task automatic load_ptr(int a);
    @(negedge clk);
    ptr_load = 1'b1; ptr_val = AW'(a);
    @(negedge clk);
    ptr_load = 1'b0;
    mptr = a;
  endtask

  task automatic load_and_write(int a, logic [7:0] d);
    @(negedge clk);
    ptr_load = 1'b1; ptr_val = AW'(a); wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    ptr_load = 1'b0; wr_en = 1'b0;
    shadow[a] = d[3:0];
    mptr = (a == NSEG-1) ? 0 : a + 1;
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    if (m_phase >= int'(mode)) begin
      m_phase = 0; m_pol = ~m_pol;
    end else begin
      m_phase++;
    end
    settle();
  endtask

  // R12: outputs held at MID while reset is asserted
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_vec("R12 reset bp", {56'd0, bp_lvl}, {56'd0, 8'h55});
    check_vec("R12 reset seg", seg_lvl, {NSEG{2'b01}});
    rst = 1'b0;
    mptr = 0; m_phase = 0; m_pol = 1'b0;
    settle();
  endtask

  // R9 R12 R6 R3 R4 R5 R2 R13: fill from reset pointer 0 then run quad frames
  task automatic t_fill_quad();
    mode = 2'd3;
    do_reset();
    for (int s = 0; s < NSEG; s++) wr_byte(8'hA0 | 8'((s * 7 + 3) & 15));
    settle();
    check_out("R9 R4 R5 quad phase0");
    for (int k = 0; k < 4; k++) begin
      tick();
      check_out("R1 R2 R3 quad step");
    end
    tick();
    check_out("R2 R13 quad second frame");
  endtask

  // R11 R10: pointer wrap and load with simultaneous write
  task automatic t_wrap();
    load_ptr(30);
    wr_byte(8'hF5);
    wr_byte(8'h0A);
    wr_byte(8'h3C);
    settle();
    check_out("R11 wrap to address 0");
    load_and_write(12, 8'hE9);
    wr_byte(8'h06);
    settle();
    check_out("R10 load with write");
    load_ptr(31);
    wr_byte(8'h0F);
    wr_byte(8'h00);
    settle();
    check_out("R11 write at last then 0");
  endtask

  // R1 R2: triplex frame length
  task automatic t_triplex();
    mode = 2'd2;
    do_reset();
    check_out("R1 triplex phase0");
    for (int k = 0; k < 4; k++) begin
      tick();
      check_out("R1 R2 triplex step");
    end
  endtask

  // R7 R5: static banks and off code following backplane
  task automatic t_static();
    mode = 2'd0;
    do_reset();
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      bank_sel = 2'(b);
      settle();
      check_out("R7 R5 static bank");
    end
    tick();
    check_out("R2 R5 static inverted");
    tick();
    check_out("R2 static back");
  endtask

  // R8: duplex banks, bank_sel[1] ignored
  task automatic t_duplex();
    mode = 2'd1;
    do_reset();
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      bank_sel = 2'(b);
      settle();
      check_out("R8 duplex bank phase0");
      tick();
      check_out("R8 duplex bank phase1");
      tick();
    end
  endtask

  // R6: bank_sel has no effect in quad and triplex
  task automatic t_bank_ignored();
    mode = 2'd3;
    do_reset();
    tick();
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      bank_sel = 2'(b);
      settle();
      check_out("R6 quad bank ignored");
    end
    @(negedge clk);
    mode = 2'd2;
    settle();
    check_out("R6 triplex bank ignored");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSEG; s++) shadow[s] = 4'h0;
    t_reset();
    t_fill_quad();
    t_wrap();
    t_triplex();
    t_static();
    t_duplex();
    t_bank_ignored();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule